// File: doc/BRIEF.md
# Receive Character Buffer with Error Status

This block sits between a serial receive deserializer and the register file of a serial port. Each character that the deserializer delivers arrives with three error flags: framing, parity and break. The block stores the character and its flags as one 12-bit entry. A fourth flag, overrun, is added to the entry when a later character has to be dropped because there is no room for it. Software reads the oldest entry through the data-register read strobe. It reads the accumulated error state through a separate status output. A write strobe clears that status.

A mode input selects between a 16-entry first-in first-out queue and a single holding register. The empty and full flags follow whichever capacity is in force. The status output behaves in two different ways. Its framing, parity and break bits change only when a character is read from the data register. Its overrun bit is set as soon as a character is lost.

Top module: `rx_status_buffer`

## Requirements
- R1: After reset, `empty` is 1, `full` is 0, `status` is 0 and `rd_word` is 0.
- R2: `rd_word` presents the oldest stored entry. The data byte is in bits 7:0, framing in bit 8, parity in bit 9, break in bit 10 and overrun in bit 11. It reads 0 while the buffer is empty.
- R3: With `fifo_mode` at 1, up to 16 characters are held and are read back in arrival order.
- R4: With `fifo_mode` at 0, a single character is held. A second arrival before that character is read is an overrun.
- R5: `empty` is 1 exactly when nothing is stored. `full` is 1 when the stored count reaches the capacity of the current mode (16 or 1). Both change on the clock edge after the push or read.
- R6: Bits 2:0 of `status` (framing bit 0, parity bit 1, break bit 2) take the flags of the character removed by a data read, on the edge of that read. A character's arrival does not change them.
- R7: A character that arrives while `full` is 1 is discarded and does not enter the buffer. Bit 3 of `status` (overrun) becomes 1 on the edge of that arrival.
- R8: On an overrun, bit 11 of the most recently stored entry is set. It is reported when that entry is read.
- R9: A pulse on `err_clr` sets all four `status` bits to 0.
- R10: A data read while the buffer is empty changes neither `status` nor the flags.
- R11: If a data read and `err_clr` fall in the same cycle, bits 2:0 take the read character's flags and bit 3 becomes 0. If an overrun and `err_clr` fall in the same cycle, bit 3 becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_mode | input | 1 | 1: 16-entry queue, 0: single holding register |
| wr_valid | input | 1 | Deserializer delivers a character this cycle |
| wr_data | input | 8 | Received character |
| wr_frame_err | input | 1 | Framing error of the character |
| wr_parity_err | input | 1 | Parity error of the character |
| wr_break | input | 1 | Break condition with the character |
| rd_req | input | 1 | Data-register read strobe, removes the oldest entry |
| err_clr | input | 1 | Error-clear write strobe |
| rd_word | output | 12 | Oldest entry: data and four flags |
| status | output | 4 | Latched status: overrun, break, parity, framing |
| empty | output | 1 | Nothing stored |
| full | output | 1 | Stored count at the capacity of the mode |

## Verification
The embedded assertions watch four things on every cycle. The count stays within range and never shows empty and full together. Overrun reaches the status on the next edge. Status bits 2:0 copy the flags of the entry just removed, and nothing else changes them. The count holds when there is no push and no pop. Other behaviour needs the bench's scenarios: whole-queue ordering, overrun marking of the newest entry seen only when it is read, the capacity change between modes, and the priority when a clear coincides with a read or an overrun.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
    typedef struct packed {
        logic       ovr;
        logic       brk;
        logic       par;
        logic       frm;
        logic [7:0] data;
    } entry_t;

    typedef struct packed {
        logic ovr;
        logic brk;
        logic par;
        logic frm;
    } stat_t;
endpackage

// File: rtl/rxb_store.sv
module rxb_store
    import rxb_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   fifo_mode,
    input  logic   wr_valid,
    input  entry_t wr_entry,
    input  logic   rd_req,
    output entry_t head,
    output logic   pop_fire,
    output logic   ovr_fire,
    output logic   empty,
    output logic   full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] CAP_FIFO = CW'(DEPTH);
    localparam logic [CW-1:0] CAP_CHAR = CW'(1);

    typedef struct packed {
        entry_t [DEPTH-1:0] mem;
        logic [AW-1:0]      wptr;
        logic [AW-1:0]      rptr;
        logic [CW-1:0]      count;
    } state_t;

    state_t st_d, st_q;
    logic   push_ok;
    logic [AW-1:0] last_w;

    assign empty    = (st_q.count == '0);
    assign full     = (st_q.count >= (fifo_mode ? CAP_FIFO : CAP_CHAR));
    assign pop_fire = rd_req && !empty;
    assign push_ok  = wr_valid && !full;
    assign ovr_fire = wr_valid && full;
    assign head     = empty ? '0 : st_q.mem[st_q.rptr];
    assign last_w   = (st_q.wptr == '0) ? LAST : st_q.wptr - 1'b1;

    always_comb begin
        st_d = st_q;
        if (push_ok) begin
            st_d.mem[st_q.wptr] = wr_entry;
            st_d.mem[st_q.wptr].ovr = 1'b0;
            st_d.wptr = (st_q.wptr == LAST) ? '0 : st_q.wptr + 1'b1;
        end
        if (ovr_fire) begin
            st_d.mem[last_w].ovr = 1'b1;
        end
        if (pop_fire) begin
            st_d.rptr = (st_q.rptr == LAST) ? '0 : st_q.rptr + 1'b1;
        end
        if (push_ok && !pop_fire) begin
            st_d.count = st_q.count + 1'b1;
        end else if (pop_fire && !push_ok) begin
            st_d.count = st_q.count - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.count <= CAP_FIFO);
    a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(empty && full));
    a_r7_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!push_ok && !pop_fire) |=> $stable(st_q.count));
    a_r4_char_single: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_mode && !empty) |-> full);
endmodule

// File: rtl/rxb_status.sv
module rxb_status
    import rxb_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   pop_fire,
    input  entry_t head,
    input  logic   ovr_fire,
    input  logic   err_clr,
    output stat_t  stat
);
    stat_t stat_d, stat_q;

    always_comb begin
        stat_d = stat_q;
        if (err_clr) begin
            stat_d = '0;
        end
        if (pop_fire) begin
            stat_d.frm = head.frm;
            stat_d.par = head.par;
            stat_d.brk = head.brk;
        end
        if (ovr_fire) begin
            stat_d.ovr = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= stat_d;
        end
    end

    assign stat = stat_q;

    a_r7_overrun_now: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_fire |=> stat_q.ovr);
    a_r6_latch_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        pop_fire |=> (stat_q.frm == $past(head.frm) && stat_q.par == $past(head.par)
                      && stat_q.brk == $past(head.brk)));
    a_r6_no_change_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!pop_fire && !err_clr) |=> ($stable(stat_q.frm) && $stable(stat_q.par)
                                     && $stable(stat_q.brk)));
endmodule

// File: rtl/rx_status_buffer.sv
module rx_status_buffer
    import rxb_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fifo_mode,
    input  logic        wr_valid,
    input  logic [7:0]  wr_data,
    input  logic        wr_frame_err,
    input  logic        wr_parity_err,
    input  logic        wr_break,
    input  logic        rd_req,
    input  logic        err_clr,
    output logic [11:0] rd_word,
    output logic [3:0]  status,
    output logic        empty,
    output logic        full
);
    entry_t wr_entry, head;
    stat_t  stat;
    logic   pop_fire, ovr_fire;

    assign wr_entry = '{ovr: 1'b0, brk: wr_break, par: wr_parity_err,
                        frm: wr_frame_err, data: wr_data};

    rxb_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .wr_valid(wr_valid),
        .wr_entry(wr_entry), .rd_req(rd_req), .head(head), .pop_fire(pop_fire),
        .ovr_fire(ovr_fire), .empty(empty), .full(full)
    );

    rxb_status u_status (
        .clk(clk), .rst_n(rst_n), .pop_fire(pop_fire), .head(head),
        .ovr_fire(ovr_fire), .err_clr(err_clr), .stat(stat)
    );

    assign rd_word = head;
    assign status  = stat;
endmodule

// File: tb/sim_rx_status_buffer.sv
module sim_rx_status_buffer;
    logic clk = 0, rst_n = 0;
    logic fifo_mode = 0, wr_valid = 0, rd_req = 0, err_clr = 0;
    logic [7:0] wr_data = 0;
    logic wr_frame_err = 0, wr_parity_err = 0, wr_break = 0;
    logic [11:0] rd_word;
    logic [3:0] status;
    logic empty, full;
    int checks = 0, failures = 0;
    logic [11:0] exp_q[$];
    logic [3:0] exp_stat = 0;

    always #10 clk = ~clk;

    rx_status_buffer u0 (.*);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int cap();
        return fifo_mode ? 16 : 1;
    endfunction

    // driver: pushes one character and updates the expected model
    task automatic push(logic [7:0] d, logic f, logic p, logic b);
        @(negedge clk);
        wr_valid = 1; wr_data = d; wr_frame_err = f; wr_parity_err = p; wr_break = b;
        @(negedge clk);
        wr_valid = 0;
        if (exp_q.size() < cap()) exp_q.push_back({1'b0, b, p, f, d});
        else begin
            logic [11:0] t;
            t = exp_q[exp_q.size()-1]; t[11] = 1'b1; exp_q[exp_q.size()-1] = t;
            exp_stat[3] = 1'b1;
        end
    endtask

    // monitor: compares the head, pops it, then compares status
    task automatic pull(string req);
        logic [11:0] e;
        @(negedge clk);
        e = (exp_q.size() == 0) ? 12'h0 : exp_q[0];
        chk(req, rd_word, e);
        rd_req = 1;
        @(negedge clk);
        rd_req = 0;
        if (exp_q.size() != 0) begin
            exp_stat[2:0] = e[10:8];
            void'(exp_q.pop_front());
        end
        chk(req, status, exp_stat);
    endtask

    task automatic flags(string req);
        chk(req, empty, exp_q.size() == 0);
        chk(req, full, exp_q.size() >= cap());
    endtask

    initial begin
        #4000000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 empty", empty, 1); chk("R1 full", full, 0);
        chk("R1 status", status, 0); chk("R1 word", rd_word, 0);

        // character mode
        fifo_mode = 0;
        push(8'hA5, 1, 0, 0);
        flags("R4 R5 char full");
        chk("R6 arrival keeps status", status, 0);
        push(8'h3C, 0, 1, 1);
        chk("R7 overrun immediate", status, 4'b1000);
        flags("R7 discard");
        pull("R8 R2 word with overrun");
        flags("R5 empty after read");
        @(negedge clk); err_clr = 1; @(negedge clk); err_clr = 0; exp_stat = 0;
        chk("R9 clear", status, 0);
        push(8'h11, 0, 1, 0);
        pull("R6 parity latched");
        pull("R10 empty read");
        flags("R10 flags");

        // FIFO mode
        @(negedge clk); err_clr = 1; @(negedge clk); err_clr = 0; exp_stat = 0;
        fifo_mode = 1;
        for (int i = 0; i < 15; i++) push(8'(i * 7 + 1), i[0], i[1], i[2]);
        flags("R5 not full at 15");
        push(8'hEE, 0, 0, 1);
        flags("R3 full at 16");
        push(8'h77, 1, 1, 1);
        chk("R7 fifo overrun", status, 4'b1000);
        for (int i = 0; i < 16; i++) pull("R3 R8 order");
        flags("R3 drained");

        // simultaneous read and clear
        push(8'h5A, 0, 0, 1);
        @(negedge clk); rd_req = 1; err_clr = 1;
        @(negedge clk); rd_req = 0; err_clr = 0;
        void'(exp_q.pop_front()); exp_stat = 4'b0100;
        chk("R11 read beats clear", status, exp_stat);
        // overrun with clear
        fifo_mode = 0;
        push(8'h01, 0, 0, 0);
        @(negedge clk); wr_valid = 1; wr_data = 8'h02; err_clr = 1;
        @(negedge clk); wr_valid = 0; err_clr = 0;
        chk("R11 overrun beats clear", status, 4'b1000);
        chk("R11 R8 word", rd_word, 12'h801);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule